// File: doc/BRIEF.md
# Four-State Write-Update Snooping Line Controller

This block keeps the coherence state of every line in a small direct-mapped cache. The cache belongs to one processor on a shared snooping bus and runs a four-state write-update protocol. A line that is resident is always valid. It is either held alone, clean (Exclusive) or possibly dirty (Modified), or held by several caches, clean (Shared-Clean) or as the possibly-dirty owner (Shared-Modified).

Processor reads and writes complete in one cycle. A miss issues a bus read and samples the wired-OR shared line in that same cycle. The line is then installed from the fill data presented with the request, because the cache allocates on writes as well as reads. A write to a line that other caches also hold broadcasts only the written word; the other copies are updated, never purged.

On the snoop side the block answers bus reads, bus word updates and flushes seen on the bus. It drives the shared line for lines it holds. It supplies the whole line when it owns a dirty copy. When it evicts a dirty line it emits a write-back with the victim's line address and data.

Top module: `dragon_snoop_ctrl`

## Requirements
- R1: After reset no line is resident and every registered output is 0. The first access to any address is reported as a miss.
- R2: Word addresses are split as follows: bits [1:0] select the word, bits [4:2] select the line, and bits [15:5] are the tag. A read miss raises busRd one cycle later, with busAddr equal to the request address. It installs the line as Shared-Clean (state code 1) if shareIn was 1 and as Exclusive (code 0) otherwise. cpuRdata returns word w of fillLine, taken from bits [16w+15:16w]. State codes are Exclusive 0, Shared-Clean 1, Shared-Modified 2 and Modified 3.
- R3: A read hit returns the stored word, issues no bus request and leaves the state as it was. cpuHit=1 and cpuState reports the state.
- R4: A write hit to an Exclusive or Modified line leaves the line Modified and issues no bus request.
- R5: A write hit to a Shared-Clean or Shared-Modified line raises busUpd, with busAddr and busWord set to the written address and word. The line becomes Shared-Modified if shareIn was 1 and Modified if it was 0.
- R6: A write miss raises busRd and merges the written word into the fill. If shareIn=1 it also raises busUpd and installs the line Shared-Modified. If shareIn=0 it installs the line Modified with no update.
- R7: A snooped bus read (snoopOp=1) to a Modified or Shared-Modified line leaves it Shared-Modified. The next cycle raises supplyValid with the full line. A snooped bus read to an Exclusive line moves it to Shared-Clean without supplying data.
- R8: A snooped update (snoopOp=2) to a Shared-Clean or Shared-Modified line writes snoopWord into the addressed word only and leaves the line Shared-Clean. A snooped update never removes a line, and it has no effect on an Exclusive or Modified line.
- R9: A snooped flush (snoopOp=3), and any snoop to an address that is not resident, changes no state and no data and supplies nothing.
- R10: shareOut is 1, combinationally, exactly while a snooped read or update hits a resident line.
- R11: A miss whose victim is Modified or Shared-Modified raises wbValid, with wbAddr set to the victim's line address (word bits 0) and wbLine set to its data. A victim that is Exclusive or Shared-Clean causes no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Processor request this cycle |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 16 | Processor word address |
| cpuWdata | input | 16 | Processor write word |
| fillLine | input | 64 | Line data from the bus for a miss, sampled with the request |
| shareIn | input | 1 | Wired-OR shared line, sampled with the request |
| snoopOp | input | 2 | Snooped transaction: 0 idle, 1 read, 2 update, 3 flush |
| snoopAddr | input | 16 | Snooped word address |
| snoopWord | input | 16 | Snooped update word |
| cpuDone | output | 1 | Request completed (one cycle after it) |
| cpuHit | output | 1 | Completed request hit |
| cpuState | output | 2 | Line state after the request |
| cpuRdata | output | 16 | Read word, or written word on a write |
| busRd | output | 1 | Bus read issued |
| busUpd | output | 1 | Bus word update issued |
| busAddr | output | 16 | Address of the bus read or update |
| busWord | output | 16 | Word broadcast with busUpd |
| wbValid | output | 1 | Write-back of a dirty victim |
| wbAddr | output | 16 | Victim line address |
| wbLine | output | 64 | Victim line data |
| shareOut | output | 1 | This cache holds the snooped line |
| supplyValid | output | 1 | Line supplied for a snooped read |
| supplyLine | output | 64 | Supplied line data |

## Verification
The assertions assume that processor requests and snooped transactions never share a cycle, since bus arbitration outside the block serialises them. The assertions also take shareIn and fillLine to be meaningful only in a request cycle. The bench keeps to this: it issues each processor request or snoop alone, with an idle cycle after it. It returns shareIn to 0 and snoopOp to idle between operations.

// File: rtl/dragon_pkg.sv
package dragon_pkg;

  typedef enum logic [1:0] {
    ST_EXCL   = 2'd0,
    ST_SCLEAN = 2'd1,
    ST_SMOD   = 2'd2,
    ST_MOD    = 2'd3
  } lineState_e;

  typedef enum logic [1:0] {
    SN_IDLE   = 2'd0,
    SN_READ   = 2'd1,
    SN_UPDATE = 2'd2,
    SN_FLUSH  = 2'd3
  } snoopOp_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic fill;   // install fill data in the processor line
    logic cpuWr;  // write processor word
    logic cpuRd;  // return stored word
    logic snpWr;  // write snooped word
    logic snpRd;  // capture snooped line for supply
    logic evict;  // capture victim line for write-back
  } strobe_t;

endpackage

// File: rtl/dragon_ctrl.sv
module dragon_ctrl
  import dragon_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORDS  = 4,
  parameter int LINES  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              shareIn,
  input  logic [1:0]        snoopOp,
  input  logic [ADDR_W-1:0] snoopAddr,
  output strobe_t           strobe,
  output logic              cpuDone,
  output logic              cpuHit,
  output logic [1:0]        cpuState,
  output logic              busRd,
  output logic              busUpd,
  output logic [ADDR_W-1:0] busAddr,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr,
  output logic              shareOut,
  output logic              supplyValid
);

  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  logic [LINES-1:0] present;
  logic [TAG_W-1:0] tagMem [LINES];
  lineState_e       stMem  [LINES];

  logic [IDX_W-1:0] cIdx, sIdx;
  logic [TAG_W-1:0] cTag, sTag;
  logic             cHit, sHit, snpActive, victimDirty;
  lineState_e       cOld, sOld, cNext, sNext;
  logic             needRd, needUpd;
  snoopOp_e         sOp;
  lineState_e       cpuStateQ;

  assign cIdx      = cpuAddr[OFF_W +: IDX_W];
  assign cTag      = cpuAddr[ADDR_W-1 -: TAG_W];
  assign sIdx      = snoopAddr[OFF_W +: IDX_W];
  assign sTag      = snoopAddr[ADDR_W-1 -: TAG_W];
  assign sOp       = snoopOp_e'(snoopOp);
  assign cOld      = stMem[cIdx];
  assign sOld      = stMem[sIdx];
  assign cHit      = present[cIdx] && (tagMem[cIdx] == cTag);
  assign sHit      = present[sIdx] && (tagMem[sIdx] == sTag);
  assign snpActive = (sOp != SN_IDLE);
  assign victimDirty = present[cIdx] && !cHit &&
                       ((cOld == ST_MOD) || (cOld == ST_SMOD));
  assign shareOut  = sHit && ((sOp == SN_READ) || (sOp == SN_UPDATE));
  assign cpuState  = cpuStateQ;

  // processor side decision
  always_comb begin
    strobe.fill  = 1'b0;
    strobe.cpuWr = 1'b0;
    strobe.cpuRd = 1'b0;
    strobe.evict = 1'b0;
    cNext   = cOld;
    needRd  = 1'b0;
    needUpd = 1'b0;
    if (cpuValid) begin
      if (cHit) begin
        if (cpuWrite) begin
          strobe.cpuWr = 1'b1;
          unique case (cOld)
            ST_EXCL, ST_MOD: cNext = ST_MOD;
            default: begin
              needUpd = 1'b1;
              cNext   = shareIn ? ST_SMOD : ST_MOD;
            end
          endcase
        end else begin
          strobe.cpuRd = 1'b1;
        end
      end else begin
        needRd       = 1'b1;
        strobe.fill  = 1'b1;
        strobe.evict = victimDirty;
        if (cpuWrite) begin
          strobe.cpuWr = 1'b1;
          needUpd      = shareIn;
          cNext        = shareIn ? ST_SMOD : ST_MOD;
        end else begin
          strobe.cpuRd = 1'b1;
          cNext        = shareIn ? ST_SCLEAN : ST_EXCL;
        end
      end
    end
  end

  // snoop side decision
  always_comb begin
    strobe.snpWr = 1'b0;
    strobe.snpRd = 1'b0;
    sNext        = sOld;
    if (snpActive && sHit) begin
      unique case (sOp)
        SN_READ: begin
          if ((sOld == ST_MOD) || (sOld == ST_SMOD)) begin
            strobe.snpRd = 1'b1;
            sNext        = ST_SMOD;
          end else begin
            sNext = ST_SCLEAN;
          end
        end
        SN_UPDATE: begin
          if ((sOld == ST_SCLEAN) || (sOld == ST_SMOD)) begin
            strobe.snpWr = 1'b1;
            sNext        = ST_SCLEAN;
          end
        end
        default: sNext = sOld;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      present     <= '0;
      cpuDone     <= 1'b0;
      cpuHit      <= 1'b0;
      cpuStateQ   <= ST_EXCL;
      busRd       <= 1'b0;
      busUpd      <= 1'b0;
      busAddr     <= '0;
      wbValid     <= 1'b0;
      wbAddr      <= '0;
      supplyValid <= 1'b0;
    end else begin
      cpuDone     <= cpuValid;
      cpuHit      <= cpuValid && cHit;
      busRd       <= needRd;
      busUpd      <= needUpd;
      wbValid     <= strobe.evict;
      supplyValid <= strobe.snpRd;
      if (cpuValid) begin
        cpuStateQ     <= cNext;
        busAddr       <= cpuAddr;
        present[cIdx] <= 1'b1;
        tagMem[cIdx]  <= cTag;
        stMem[cIdx]   <= cNext;
      end
      if (strobe.evict) begin
        wbAddr <= {tagMem[cIdx], cIdx, {OFF_W{1'b0}}};
      end
      if (snpActive && sHit) begin
        stMem[sIdx] <= sNext;
      end
    end
  end

  // R2 arbitration keeps processor and snoop apart
  snoop_cpu_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuValid |-> (sOp == SN_IDLE));

  // R2
  bus_from_cpu_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd || busUpd) |-> cpuDone);

  // R2
  read_miss_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && !busUpd) |-> (cpuStateQ != ST_SMOD));

  // R4
  silent_excl_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && cpuWrite && cHit && ((cOld == ST_EXCL) || (cOld == ST_MOD)))
      |=> (!busRd && !busUpd && (cpuStateQ == ST_MOD)));

  // R5
  upd_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    busUpd |-> ((cpuStateQ == ST_SMOD) || (cpuStateQ == ST_MOD)));

  // R6
  write_miss_shared_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busUpd && busRd) |-> (cpuStateQ == ST_SMOD));

  // R7
  supply_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    supplyValid |-> ($past(sOp) == SN_READ));

  // R9
  flush_no_supply_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sOp == SN_FLUSH) |=> !supplyValid);

  // R10
  share_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    shareOut |-> ((sOp == SN_READ) || (sOp == SN_UPDATE)));

  // R11
  wb_with_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (busRd && !cpuHit));

endmodule

// File: rtl/dragon_data.sv
module dragon_data
  import dragon_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int WORDS  = 4,
  parameter int LINES  = 8,
  localparam int OFF_W  = $clog2(WORDS),
  localparam int IDX_W  = $clog2(LINES),
  localparam int LOW_W  = OFF_W + IDX_W,
  localparam int LINE_W = WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [LOW_W-1:0]  cpuLow,
  input  logic [WORD_W-1:0] cpuWdata,
  input  logic [LINE_W-1:0] fillLine,
  input  logic [LOW_W-1:0]  snoopLow,
  input  logic [WORD_W-1:0] snoopWord,
  output logic [WORD_W-1:0] cpuRdata,
  output logic [WORD_W-1:0] busWord,
  output logic [LINE_W-1:0] wbLine,
  output logic [LINE_W-1:0] supplyLine
);

  logic [WORD_W-1:0] mem [LINES][WORDS];

  logic [OFF_W-1:0] cOff, sOff;
  logic [IDX_W-1:0] cIdx, sIdx;
  logic [LINE_W-1:0] cLine, sLine;
  logic [WORD_W-1:0] fillWord;

  assign cOff = cpuLow[OFF_W-1:0];
  assign cIdx = cpuLow[LOW_W-1:OFF_W];
  assign sOff = snoopLow[OFF_W-1:0];
  assign sIdx = snoopLow[LOW_W-1:OFF_W];
  assign fillWord = fillLine[cOff*WORD_W +: WORD_W];

  // packed views of the two addressed lines
  for (genvar w = 0; w < WORDS; w++) begin : g_pack
    assign cLine[w*WORD_W +: WORD_W] = mem[cIdx][w];
    assign sLine[w*WORD_W +: WORD_W] = mem[sIdx][w];
  end

  always_ff @(posedge clk) begin
    for (int w = 0; w < WORDS; w++) begin
      if (strobe.fill) begin
        mem[cIdx][w] <= (strobe.cpuWr && (cOff == OFF_W'(w))) ?
                        cpuWdata : fillLine[w*WORD_W +: WORD_W];
      end else if (strobe.cpuWr && (cOff == OFF_W'(w))) begin
        mem[cIdx][w] <= cpuWdata;
      end
      if (strobe.snpWr && (sOff == OFF_W'(w))) begin
        mem[sIdx][w] <= snoopWord;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuRdata   <= '0;
      busWord    <= '0;
      wbLine     <= '0;
      supplyLine <= '0;
    end else begin
      if (strobe.cpuWr) begin
        cpuRdata <= cpuWdata;
        busWord  <= cpuWdata;
      end else if (strobe.fill) begin
        cpuRdata <= fillWord;
      end else if (strobe.cpuRd) begin
        cpuRdata <= mem[cIdx][cOff];
      end
      if (strobe.evict) wbLine <= cLine;
      if (strobe.snpRd) supplyLine <= sLine;
    end
  end

  // R11 a write-back only leaves with a fill
  evict_needs_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.evict |-> strobe.fill);

  // R8 snoop writes never coincide with processor data traffic
  snoop_wr_alone_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.snpWr |-> !(strobe.cpuWr || strobe.fill || strobe.cpuRd));

  // R6 a fill always serves a processor access
  fill_serves_cpu_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fill |-> $onehot({strobe.cpuWr, strobe.cpuRd}));

endmodule

// File: rtl/dragon_snoop_ctrl.sv
module dragon_snoop_ctrl
  import dragon_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 16,
  parameter int WORDS  = 4,
  parameter int LINES  = 8,
  localparam int LINE_W = WORDS * WORD_W,
  localparam int LOW_W  = $clog2(WORDS) + $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [WORD_W-1:0] cpuWdata,
  input  logic [LINE_W-1:0] fillLine,
  input  logic              shareIn,
  input  logic [1:0]        snoopOp,
  input  logic [ADDR_W-1:0] snoopAddr,
  input  logic [WORD_W-1:0] snoopWord,
  output logic              cpuDone,
  output logic              cpuHit,
  output logic [1:0]        cpuState,
  output logic [WORD_W-1:0] cpuRdata,
  output logic              busRd,
  output logic              busUpd,
  output logic [ADDR_W-1:0] busAddr,
  output logic [WORD_W-1:0] busWord,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [LINE_W-1:0] wbLine,
  output logic              shareOut,
  output logic              supplyValid,
  output logic [LINE_W-1:0] supplyLine
);

  strobe_t strobe;

  dragon_ctrl #(.ADDR_W(ADDR_W), .WORDS(WORDS), .LINES(LINES)) ctrl_i (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .shareIn(shareIn), .snoopOp(snoopOp),
    .snoopAddr(snoopAddr), .strobe(strobe), .cpuDone(cpuDone),
    .cpuHit(cpuHit), .cpuState(cpuState), .busRd(busRd), .busUpd(busUpd),
    .busAddr(busAddr), .wbValid(wbValid), .wbAddr(wbAddr),
    .shareOut(shareOut), .supplyValid(supplyValid)
  );

  dragon_data #(.WORD_W(WORD_W), .WORDS(WORDS), .LINES(LINES)) data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cpuLow(cpuAddr[LOW_W-1:0]), .cpuWdata(cpuWdata), .fillLine(fillLine),
    .snoopLow(snoopAddr[LOW_W-1:0]), .snoopWord(snoopWord),
    .cpuRdata(cpuRdata), .busWord(busWord), .wbLine(wbLine),
    .supplyLine(supplyLine)
  );

endmodule

// File: tb/dragon_snoop_ctrl_tb.sv
module dragon_snoop_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuValid = 1'b0, cpuWrite = 1'b0, shareIn = 1'b0;
  logic [15:0] cpuAddr = '0, cpuWdata = '0, snoopAddr = '0, snoopWord = '0;
  logic [63:0] fillLine = '0;
  logic [1:0]  snoopOp = 2'd0;
  logic        cpuDone, cpuHit, busRd, busUpd, wbValid, shareOut, supplyValid;
  logic [1:0]  cpuState;
  logic [15:0] cpuRdata, busAddr, busWord, wbAddr;
  logic [63:0] wbLine, supplyLine;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic shareSeen;

  always #4 clk = ~clk;

  dragon_snoop_ctrl dut_i (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .fillLine(fillLine),
    .shareIn(shareIn), .snoopOp(snoopOp), .snoopAddr(snoopAddr),
    .snoopWord(snoopWord), .cpuDone(cpuDone), .cpuHit(cpuHit),
    .cpuState(cpuState), .cpuRdata(cpuRdata), .busRd(busRd),
    .busUpd(busUpd), .busAddr(busAddr), .busWord(busWord),
    .wbValid(wbValid), .wbAddr(wbAddr), .wbLine(wbLine),
    .shareOut(shareOut), .supplyValid(supplyValid), .supplyLine(supplyLine)
  );

  localparam logic [1:0] EX = 2'd0, SC = 2'd1, SM = 2'd2, MO = 2'd3;

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [15:0] wdata;
    logic        share;
    logic        hit;
    logic [1:0]  st;
    logic [15:0] rdata;
    logic        rd;
    logic        upd;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 16'h0040, 16'h0000, 1'b0, 1'b0, EX, 16'h0040, 1'b1, 1'b0}, // R1 R2
    '{1'b1, 16'h0041, 16'h1111, 1'b0, 1'b1, MO, 16'h1111, 1'b0, 1'b0}, // R4
    '{1'b0, 16'h0041, 16'h0000, 1'b0, 1'b1, MO, 16'h1111, 1'b0, 1'b0}, // R3
    '{1'b0, 16'h0064, 16'h0000, 1'b1, 1'b0, SC, 16'h0064, 1'b1, 1'b0}, // R2
    '{1'b1, 16'h0066, 16'h2222, 1'b1, 1'b1, SM, 16'h2222, 1'b0, 1'b1}, // R5
    '{1'b1, 16'h0067, 16'h3333, 1'b0, 1'b1, MO, 16'h3333, 1'b0, 1'b1}, // R5
    '{1'b1, 16'h0088, 16'h4444, 1'b1, 1'b0, SM, 16'h4444, 1'b1, 1'b1}, // R6
    '{1'b1, 16'h00AC, 16'h5555, 1'b0, 1'b0, MO, 16'h5555, 1'b1, 1'b0}, // R6
    '{1'b0, 16'h00AD, 16'h0000, 1'b0, 1'b1, MO, 16'h00AD, 1'b0, 1'b0}, // R6
    '{1'b0, 16'h0089, 16'h0000, 1'b0, 1'b1, SM, 16'h0089, 1'b0, 1'b0}  // R3
  };

  function automatic logic [63:0] fillFor(logic [15:0] a);
    logic [63:0] l;
    for (int i = 0; i < 4; i++) l[i*16 +: 16] = {a[15:2], 2'(i)};
    return l;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cpuOp(logic wr, logic [15:0] a, logic [15:0] d, logic sh);
    @(negedge clk);
    cpuValid = 1'b1; cpuWrite = wr; cpuAddr = a; cpuWdata = d;
    shareIn = sh; fillLine = fillFor(a);
    @(posedge clk);
    @(negedge clk);
    cpuValid = 1'b0; shareIn = 1'b0;
  endtask

  task automatic snoop(logic [1:0] op, logic [15:0] a, logic [15:0] d);
    @(negedge clk);
    snoopOp = op; snoopAddr = a; snoopWord = d;
    #1 shareSeen = shareOut;
    @(posedge clk);
    @(negedge clk);
    snoopOp = 2'd0;
  endtask

  task automatic readState(string req, logic [15:0] a, logic [1:0] st,
                           logic [15:0] d);
    cpuOp(1'b0, a, 16'h0, 1'b0);
    chk({req, " hit"}, 64'(cpuHit), 64'd1);
    chk({req, " state"}, 64'(cpuState), 64'(st));
    chk({req, " data"}, 64'(cpuRdata), 64'(d));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done", 64'(cpuDone), 64'd0);
    chk("R1 busRd", 64'(busRd), 64'd0);
    chk("R1 wb", 64'(wbValid), 64'd0);
    chk("R1 supply", 64'(supplyValid), 64'd0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      cpuOp(VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].share);
      chk($sformatf("R2-vec%0d done", i), 64'(cpuDone), 64'd1);
      chk($sformatf("vec%0d hit (R1 R3)", i), 64'(cpuHit), 64'(VECS[i].hit));
      chk($sformatf("vec%0d state (R2 R4 R5 R6)", i), 64'(cpuState), 64'(VECS[i].st));
      chk($sformatf("vec%0d rdata (R2 R6)", i), 64'(cpuRdata), 64'(VECS[i].rdata));
      chk($sformatf("vec%0d busRd (R2 R6)", i), 64'(busRd), 64'(VECS[i].rd));
      chk($sformatf("vec%0d busUpd (R4 R5)", i), 64'(busUpd), 64'(VECS[i].upd));
      chk($sformatf("vec%0d wb (R11)", i), 64'(wbValid), 64'd0);
      if (VECS[i].upd) begin
        chk("R5 busAddr", 64'(busAddr), 64'(VECS[i].addr));
        chk("R5 busWord", 64'(busWord), 64'(VECS[i].wdata));
      end
    end

    // R11 evict a Modified line
    cpuOp(1'b0, 16'h0140, 16'h0, 1'b0);
    chk("R11 wbValid M", 64'(wbValid), 64'd1);
    chk("R11 wbAddr", 64'(wbAddr), 64'h0040);
    chk("R11 wbLine", wbLine, {16'h0043, 16'h0042, 16'h1111, 16'h0040});
    chk("R2 exclusive", 64'(cpuState), 64'(EX));
    // R11 evict an Exclusive line
    cpuOp(1'b0, 16'h0240, 16'h0, 1'b0);
    chk("R11 no wb E", 64'(wbValid), 64'd0);

    // R7 snoop read on Modified supplies
    snoop(2'd1, 16'h0064, 16'h0);
    chk("R10 shareOut M", 64'(shareSeen), 64'd1);
    chk("R7 supply M", 64'(supplyValid), 64'd1);
    chk("R7 supplyLine", supplyLine, {16'h3333, 16'h2222, 16'h0065, 16'h0064});
    readState("R7 M to SM", 16'h0064, SM, 16'h0064);

    // R7 snoop read on Exclusive
    snoop(2'd1, 16'h0240, 16'h0);
    chk("R10 shareOut E", 64'(shareSeen), 64'd1);
    chk("R7 no supply E", 64'(supplyValid), 64'd0);
    readState("R7 E to SC", 16'h0240, SC, 16'h0240);

    // R8 snooped updates
    snoop(2'd2, 16'h0089, 16'h7777);
    chk("R10 shareOut upd", 64'(shareSeen), 64'd1);
    readState("R8 SM upd", 16'h0089, SC, 16'h7777);
    readState("R8 other word", 16'h0088, SC, 16'h4444);
    snoop(2'd2, 16'h0242, 16'h8888);
    readState("R8 SC upd", 16'h0242, SC, 16'h8888);
    snoop(2'd2, 16'h00AC, 16'h1234);
    readState("R8 M ignores upd", 16'h00AC, MO, 16'h5555);

    // R9 flush and snoop miss have no effect
    snoop(2'd3, 16'h0088, 16'h9999);
    chk("R10 no shareOut flush", 64'(shareSeen), 64'd0);
    chk("R9 flush no supply", 64'(supplyValid), 64'd0);
    readState("R9 flush", 16'h0088, SC, 16'h4444);
    snoop(2'd1, 16'h0300, 16'h0);
    chk("R10 no shareOut miss", 64'(shareSeen), 64'd0);
    chk("R9 miss no supply", 64'(supplyValid), 64'd0);
    readState("R9 miss", 16'h0240, SC, 16'h0240);

    // R7 snoop read on Shared-Modified supplies
    snoop(2'd1, 16'h0064, 16'h0);
    chk("R7 supply SM", 64'(supplyValid), 64'd1);
    chk("R7 supplyLine SM", supplyLine, {16'h3333, 16'h2222, 16'h0065, 16'h0064});

    // R11 evict Shared-Modified and Shared-Clean
    cpuOp(1'b0, 16'h0264, 16'h0, 1'b0);
    chk("R11 wbValid SM", 64'(wbValid), 64'd1);
    chk("R11 wbAddr SM", 64'(wbAddr), 64'h0064);
    chk("R11 wbLine SM", wbLine, {16'h3333, 16'h2222, 16'h0065, 16'h0064});
    cpuOp(1'b0, 16'h0188, 16'h0, 1'b0);
    chk("R11 no wb SC", 64'(wbValid), 64'd0);

    // R5 write hit on Shared-Clean with sharers
    cpuOp(1'b1, 16'h0243, 16'hBEEF, 1'b1);
    chk("R5 upd SC", 64'(busUpd), 64'd1);
    chk("R5 addr SC", 64'(busAddr), 64'h0243);
    chk("R5 word SC", 64'(busWord), 64'hBEEF);
    chk("R5 state SC", 64'(cpuState), 64'(SM));

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule